// File: doc/BRIEF.md
# Virtual Wire Handshake Responder

This block answers, in hardware, the power and reset handshakes that a host controller runs with a peripheral over virtual wires. An event block in front of it delivers one-cycle strobes when an incoming warn wire changes, together with the present level of each wire. The responder drives the outgoing wire register bits that a serializer sends back: an acknowledge for each warn and the boot-load status/done pair. It also raises an out-of-band channel ready flag after a controller hardware reset and follows the platform reset level with an explicit "not yet reported" state.

Requests are queued in a pending vector and served one per clock. A sequencer state machine has the states ST_IDLE, ST_HWRST, ST_BOOT, ST_HOST, ST_OOB and ST_SUSP. At each edge it moves to the state of the highest-priority pending request, and it returns to ST_IDLE when nothing is pending. The priority, from highest to lowest, is hardware reset, boot-load check, host-reset ack, out-of-band-reset ack, suspend ack. On the edge after a state is entered, the output process applies that state's update. Entering ST_HWRST queues a boot-load check and a suspend check, so the transitions ST_HWRST -> ST_BOOT -> ST_SUSP follow unless other requests come between. Leaving reset queues the same two checks. Any group-0 event (host-reset warn, out-of-band-reset warn or platform reset) also queues a boot-load check.

Top module: `vw_handshake_responder`

## Requirements
- R1: While reset is asserted, both wire words are zero, oob_ready is 0, plat_state is 00 and plat_chg is 0. After reset the block runs a boot-load check and then a suspend check, with no input needed.
- R2: A host-reset warn strobe sets tx_wires0 bit 27 if host_warn_lvl is high when the update is applied. Because the boot-load check runs first, the bit is visible after the third clock edge that follows the strobe.
- R3: An out-of-band-reset warn strobe sets tx_wires0 bit 16 if oob_warn_lvl is high when the update is applied.
- R4: A suspend warn strobe sets tx_wires1 bit 20 if susp_warn_lvl is high when the update is applied. With nothing else pending, the bit is visible after the second edge that follows the strobe.
- R5: A boot-load check sets boot status (tx_wires0 bit 23) and boot done (tx_wires0 bit 20) in the same cycle when the status bit is clear. The two bits are always equal.
- R6: Once set, boot done stays set until g3_entry. g3_entry clears both boot bits, and they stay clear until the next boot-load check.
- R7: A hardware-reset strobe sets oob_ready (which then stays set) after the second edge that follows it. The boot-load check is applied one edge later, and the suspend check (set the suspend ack if susp_warn_lvl is high) one edge after that.
- R8: plat_state is encoded 00 unknown, 10 low, 11 high. On a platform reset strobe, or on any group-0 strobe while the state is unknown, it takes plat_rst_lvl on the next edge, and plat_chg is high for exactly that cycle. The state never returns to unknown.
- R9: Each acknowledge bit is cleared on the first edge at which its warn level is low.
- R10: Only one update is applied per clock, in the priority order hardware reset, boot-load, host, out-of-band, suspend. A strobe that is not served at once stays pending and is never lost.
- R11: A warn strobe whose level is low at apply time leaves the acknowledge bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_reset_evt | input | 1 | Controller hardware-reset strobe |
| g3_entry | input | 1 | Full power-off entry, clears the boot pair |
| host_warn_evt | input | 1 | Host-reset warn changed (group 0) |
| host_warn_lvl | input | 1 | Host-reset warn level |
| oob_warn_evt | input | 1 | Out-of-band-reset warn changed (group 0) |
| oob_warn_lvl | input | 1 | Out-of-band-reset warn level |
| susp_warn_evt | input | 1 | Suspend warn changed (group 1) |
| susp_warn_lvl | input | 1 | Suspend warn level |
| plat_rst_evt | input | 1 | Platform reset wire changed (group 0) |
| plat_rst_lvl | input | 1 | Platform reset wire level |
| tx_wires0 | output | 32 | Outgoing group-0 wire bits |
| tx_wires1 | output | 32 | Outgoing group-1 wire bits |
| oob_ready | output | 1 | Out-of-band channel ready flag |
| plat_state | output | 2 | Tracked platform reset state |
| plat_chg | output | 1 | One-cycle pulse when plat_state is captured |

## Verification
The assertions check, on every cycle, the invariants that hold at any time: the boot pair stays equal, boot done and oob_ready hold their values, an ack falls when its level is low, a captured platform state never goes back to unknown, and a hardware reset is followed by the boot-load state. Serving order, the exact cycle each update appears, and a strobe that is queued behind higher-priority work can only be seen by the scenarios. These are compared every clock against the bench's behavioural model, with directed checks for simultaneous strobes, low-level warns, power-off clearing and the hardware-reset sequence.

// File: rtl/vwh_pkg.sv
package vwh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HWRST,
        ST_BOOT,
        ST_HOST,
        ST_OOB,
        ST_SUSP
    } vwh_op_e;

    localparam int NUM_REQ = 5;
    localparam int RQ_HW   = 0;
    localparam int RQ_BOOT = 1;
    localparam int RQ_HOST = 2;
    localparam int RQ_OOB  = 3;
    localparam int RQ_SUSP = 4;

    localparam logic [1:0] PLAT_UNKNOWN = 2'b00;
    localparam logic [1:0] PLAT_LOW     = 2'b10;
    localparam logic [1:0] PLAT_HIGH    = 2'b11;
endpackage

// File: rtl/vwh_sequencer.sv
module vwh_sequencer
    import vwh_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_in,
    output vwh_op_e            op_q
);
    localparam logic [NUM_REQ-1:0] FOLLOW_UP = (NUM_REQ'(1) << RQ_BOOT) | (NUM_REQ'(1) << RQ_SUSP);

    logic [NUM_REQ-1:0] pend_q, pend_d, req_all, grant;
    vwh_op_e            op_d;

    always_comb begin
        req_all = pend_q | req_in;
        grant   = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_all[i] && (grant == '0)) grant[i] = 1'b1;
        end
        pend_d = req_all & ~grant;
        if (grant[RQ_HW]) pend_d = pend_d | FOLLOW_UP;
        op_d = ST_IDLE;
        unique case (1'b1)
            grant[RQ_HW]:   op_d = ST_HWRST;
            grant[RQ_BOOT]: op_d = ST_BOOT;
            grant[RQ_HOST]: op_d = ST_HOST;
            grant[RQ_OOB]:  op_d = ST_OOB;
            grant[RQ_SUSP]: op_d = ST_SUSP;
            default:        op_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= ST_IDLE;
            pend_q <= FOLLOW_UP;
        end else begin
            op_q   <= op_d;
            pend_q <= pend_d;
        end
    end

    // R7
    hwrst_then_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == ST_HWRST && !req_in[RQ_HW]) |=> (op_q == ST_BOOT));
    // R10
    host_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_in[RQ_HOST] |=> (pend_q[RQ_HOST] || op_q == ST_HOST));
endmodule

// File: rtl/vwh_wire_bank.sv
module vwh_wire_bank
    import vwh_pkg::*;
#(
    parameter int WIRE_W        = 32,
    parameter int HOST_ACK_BIT  = 27,
    parameter int BOOT_STS_BIT  = 23,
    parameter int BOOT_DONE_BIT = 20,
    parameter int OOB_ACK_BIT   = 16,
    parameter int SUSP_ACK_BIT  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vwh_op_e           op_q,
    input  logic              host_lvl,
    input  logic              oob_lvl,
    input  logic              susp_lvl,
    input  logic              g3_entry,
    output logic [WIRE_W-1:0] tx0,
    output logic [WIRE_W-1:0] tx1,
    output logic              oob_ready
);
    logic host_ack_q, oob_ack_q, susp_ack_q, boot_sts_q, boot_done_q, rdy_q;
    logic host_ack_d, oob_ack_d, susp_ack_d, boot_sts_d, boot_done_d, rdy_d;

    always_comb begin
        host_ack_d  = host_ack_q;
        oob_ack_d   = oob_ack_q;
        susp_ack_d  = susp_ack_q;
        boot_sts_d  = boot_sts_q;
        boot_done_d = boot_done_q;
        rdy_d       = rdy_q;
        unique case (op_q)
            ST_IDLE:  ;
            ST_HWRST: rdy_d = 1'b1;
            ST_BOOT:  if (!boot_sts_q) begin
                          boot_sts_d  = 1'b1;
                          boot_done_d = 1'b1;
                      end
            ST_HOST:  if (host_lvl) host_ack_d = 1'b1;
            ST_OOB:   if (oob_lvl)  oob_ack_d  = 1'b1;
            ST_SUSP:  if (susp_lvl) susp_ack_d = 1'b1;
            default:  ;
        endcase
        if (!host_lvl) host_ack_d = 1'b0;
        if (!oob_lvl)  oob_ack_d  = 1'b0;
        if (!susp_lvl) susp_ack_d = 1'b0;
        if (g3_entry) begin
            boot_sts_d  = 1'b0;
            boot_done_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_ack_q  <= 1'b0;
            oob_ack_q   <= 1'b0;
            susp_ack_q  <= 1'b0;
            boot_sts_q  <= 1'b0;
            boot_done_q <= 1'b0;
            rdy_q       <= 1'b0;
        end else begin
            host_ack_q  <= host_ack_d;
            oob_ack_q   <= oob_ack_d;
            susp_ack_q  <= susp_ack_d;
            boot_sts_q  <= boot_sts_d;
            boot_done_q <= boot_done_d;
            rdy_q       <= rdy_d;
        end
    end

    always_comb begin
        tx0                = '0;
        tx1                = '0;
        tx0[HOST_ACK_BIT]  = host_ack_q;
        tx0[BOOT_STS_BIT]  = boot_sts_q;
        tx0[BOOT_DONE_BIT] = boot_done_q;
        tx0[OOB_ACK_BIT]   = oob_ack_q;
        tx1[SUSP_ACK_BIT]  = susp_ack_q;
        oob_ready          = rdy_q;
    end

    // R5
    boot_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_sts_q == boot_done_q);
    // R6
    boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done_q && !g3_entry) |=> boot_done_q);
    // R7
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |=> rdy_q);
    // R9
    host_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_lvl |=> !host_ack_q);
    // R9
    susp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !susp_lvl |=> !susp_ack_q);
    // R2
    host_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == ST_HOST && host_lvl) |=> host_ack_q);
endmodule

// File: rtl/vwh_plat_track.sv
module vwh_plat_track
    import vwh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grp0_evt,
    input  logic       plat_evt,
    input  logic       plat_lvl,
    output logic [1:0] plat_state,
    output logic       plat_chg
);
    logic capture;

    always_comb capture = plat_evt || (grp0_evt && plat_state == PLAT_UNKNOWN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plat_state <= PLAT_UNKNOWN;
            plat_chg   <= 1'b0;
        end else begin
            plat_chg <= capture;
            if (capture) plat_state <= plat_lvl ? PLAT_HIGH : PLAT_LOW;
        end
    end

    // R8
    plat_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plat_state[1] |=> plat_state[1]);
    // R8
    plat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plat_chg |-> (plat_state != PLAT_UNKNOWN));
endmodule

// File: rtl/vw_handshake_responder.sv
module vw_handshake_responder
    import vwh_pkg::*;
#(
    parameter int WIRE_W        = 32,
    parameter int HOST_ACK_BIT  = 27,
    parameter int BOOT_STS_BIT  = 23,
    parameter int BOOT_DONE_BIT = 20,
    parameter int OOB_ACK_BIT   = 16,
    parameter int SUSP_ACK_BIT  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_reset_evt,
    input  logic              g3_entry,
    input  logic              host_warn_evt,
    input  logic              host_warn_lvl,
    input  logic              oob_warn_evt,
    input  logic              oob_warn_lvl,
    input  logic              susp_warn_evt,
    input  logic              susp_warn_lvl,
    input  logic              plat_rst_evt,
    input  logic              plat_rst_lvl,
    output logic [WIRE_W-1:0] tx_wires0,
    output logic [WIRE_W-1:0] tx_wires1,
    output logic              oob_ready,
    output logic [1:0]        plat_state,
    output logic              plat_chg
);
    logic               grp0_evt;
    logic [NUM_REQ-1:0] req_in;
    vwh_op_e            op_q;

    always_comb begin
        grp0_evt        = host_warn_evt | oob_warn_evt | plat_rst_evt;
        req_in          = '0;
        req_in[RQ_HW]   = hw_reset_evt;
        req_in[RQ_BOOT] = grp0_evt;
        req_in[RQ_HOST] = host_warn_evt;
        req_in[RQ_OOB]  = oob_warn_evt;
        req_in[RQ_SUSP] = susp_warn_evt;
    end

    vwh_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (req_in),
        .op_q   (op_q)
    );

    vwh_wire_bank #(
        .WIRE_W        (WIRE_W),
        .HOST_ACK_BIT  (HOST_ACK_BIT),
        .BOOT_STS_BIT  (BOOT_STS_BIT),
        .BOOT_DONE_BIT (BOOT_DONE_BIT),
        .OOB_ACK_BIT   (OOB_ACK_BIT),
        .SUSP_ACK_BIT  (SUSP_ACK_BIT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_q      (op_q),
        .host_lvl  (host_warn_lvl),
        .oob_lvl   (oob_warn_lvl),
        .susp_lvl  (susp_warn_lvl),
        .g3_entry  (g3_entry),
        .tx0       (tx_wires0),
        .tx1       (tx_wires1),
        .oob_ready (oob_ready)
    );

    vwh_plat_track u_plat (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp0_evt   (grp0_evt),
        .plat_evt   (plat_rst_evt),
        .plat_lvl   (plat_rst_lvl),
        .plat_state (plat_state),
        .plat_chg   (plat_chg)
    );
endmodule

// File: tb/vw_handshake_responder_test.sv
module vw_handshake_responder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_reset_evt = 1'b0, g3_entry = 1'b0;
    logic        host_warn_evt = 1'b0, host_warn_lvl = 1'b0;
    logic        oob_warn_evt = 1'b0, oob_warn_lvl = 1'b0;
    logic        susp_warn_evt = 1'b0, susp_warn_lvl = 1'b0;
    logic        plat_rst_evt = 1'b0, plat_rst_lvl = 1'b0;
    logic [31:0] tx_wires0, tx_wires1;
    logic        oob_ready, plat_chg;
    logic [1:0]  plat_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    vw_handshake_responder uut (
        .clk(clk), .rst_n(rst_n), .hw_reset_evt(hw_reset_evt), .g3_entry(g3_entry),
        .host_warn_evt(host_warn_evt), .host_warn_lvl(host_warn_lvl),
        .oob_warn_evt(oob_warn_evt), .oob_warn_lvl(oob_warn_lvl),
        .susp_warn_evt(susp_warn_evt), .susp_warn_lvl(susp_warn_lvl),
        .plat_rst_evt(plat_rst_evt), .plat_rst_lvl(plat_rst_lvl),
        .tx_wires0(tx_wires0), .tx_wires1(tx_wires1), .oob_ready(oob_ready),
        .plat_state(plat_state), .plat_chg(plat_chg)
    );

    // behavioural reference: request index 0 hw,1 boot,2 host,3 oob,4 susp
    int m_pend = 18;
    int m_op = -1;
    int m_req, m_g;
    bit m_g0;
    bit m_hack = 0, m_oack = 0, m_sack = 0, m_bsts = 0, m_bdone = 0, m_rdy = 0, m_chg = 0;
    bit [1:0] m_plat = 2'b00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = 18; m_op = -1;
            m_hack = 0; m_oack = 0; m_sack = 0; m_bsts = 0; m_bdone = 0; m_rdy = 0;
            m_chg = 0; m_plat = 2'b00;
        end else begin
            m_g0  = host_warn_evt | oob_warn_evt | plat_rst_evt;
            m_req = m_pend | (hw_reset_evt ? 1 : 0) | (m_g0 ? 2 : 0) | (host_warn_evt ? 4 : 0)
                    | (oob_warn_evt ? 8 : 0) | (susp_warn_evt ? 16 : 0);
            m_g = -1;
            for (int i = 0; i < 5; i++) if (m_g < 0 && ((m_req >> i) & 1) == 1) m_g = i;
            if (m_op == 0) m_rdy = 1;
            if (m_op == 1 && !m_bsts) begin m_bsts = 1; m_bdone = 1; end
            if (m_op == 2 && host_warn_lvl) m_hack = 1;
            if (m_op == 3 && oob_warn_lvl) m_oack = 1;
            if (m_op == 4 && susp_warn_lvl) m_sack = 1;
            if (!host_warn_lvl) m_hack = 0;
            if (!oob_warn_lvl) m_oack = 0;
            if (!susp_warn_lvl) m_sack = 0;
            if (g3_entry) begin m_bsts = 0; m_bdone = 0; end
            m_chg = 0;
            if (plat_rst_evt || (m_g0 && m_plat == 2'b00)) begin
                m_plat = plat_rst_lvl ? 2'b11 : 2'b10;
                m_chg = 1;
            end
            if (m_g >= 0) m_pend = m_req & ~(1 << m_g);
            else m_pend = m_req;
            if (m_g == 0) m_pend = m_pend | 18;
            m_op = m_g;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R10 model tx_wires0", tx_wires0,
                  (32'(m_hack) << 27) | (32'(m_bsts) << 23) | (32'(m_bdone) << 20) | (32'(m_oack) << 16));
            check("R10 model tx_wires1", tx_wires1, 32'(m_sack) << 20);
            check("R7 model oob_ready", 32'(oob_ready), 32'(m_rdy));
            check("R8 model plat_state", 32'(plat_state), 32'(m_plat));
            check("R8 model plat_chg", 32'(plat_chg), 32'(m_chg));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        step(3);
        check("R1 reset tx_wires0", tx_wires0, 32'h0);
        check("R1 reset tx_wires1", tx_wires1, 32'h0);
        check("R1 reset oob_ready", 32'(oob_ready), 32'h0);
        check("R1 reset plat_state", 32'(plat_state), 32'h0);
        rst_n = 1'b1;
        cmp_on = 1;
        step(3);
        check("R1 R5 startup boot pair", tx_wires0, 32'h0090_0000);
        check("R1 startup suspend check, level low", tx_wires1, 32'h0);

        // host warn, also first group-0 event
        host_warn_lvl = 1'b1; host_warn_evt = 1'b1;
        step(1); host_warn_evt = 1'b0;
        check("R8 first group0 captures low", 32'(plat_state), 32'h2);
        check("R8 change pulse", 32'(plat_chg), 32'h1);
        step(1);
        check("R8 pulse one cycle", 32'(plat_chg), 32'h0);
        step(1);
        check("R2 host ack set", tx_wires0, 32'h0890_0000);
        host_warn_lvl = 1'b0;
        step(1);
        check("R9 host ack cleared", tx_wires0, 32'h0090_0000);

        oob_warn_lvl = 1'b1; oob_warn_evt = 1'b1;
        step(1); oob_warn_evt = 1'b0;
        step(2);
        check("R3 oob ack set", tx_wires0, 32'h0091_0000);
        oob_warn_lvl = 1'b0;
        step(1);

        susp_warn_lvl = 1'b1; susp_warn_evt = 1'b1;
        step(1); susp_warn_evt = 1'b0;
        step(1);
        check("R4 suspend ack set", tx_wires1, 32'h0010_0000);
        susp_warn_lvl = 1'b0;
        step(1);
        check("R9 suspend ack cleared", tx_wires1, 32'h0);

        host_warn_evt = 1'b1;
        step(1); host_warn_evt = 1'b0;
        step(3);
        check("R11 low-level warn ignored", tx_wires0, 32'h0090_0000);

        host_warn_lvl = 1'b1; oob_warn_lvl = 1'b1; susp_warn_lvl = 1'b1;
        host_warn_evt = 1'b1; oob_warn_evt = 1'b1; susp_warn_evt = 1'b1;
        step(1);
        host_warn_evt = 1'b0; oob_warn_evt = 1'b0; susp_warn_evt = 1'b0;
        step(2);
        check("R10 host served first", tx_wires0, 32'h0890_0000);
        check("R10 suspend still queued", tx_wires1, 32'h0);
        step(1);
        check("R10 oob served second", tx_wires0, 32'h0891_0000);
        check("R10 suspend still queued after oob", tx_wires1, 32'h0);
        step(1);
        check("R10 suspend served last", tx_wires1, 32'h0010_0000);
        host_warn_lvl = 1'b0; oob_warn_lvl = 1'b0; susp_warn_lvl = 1'b0;
        step(2);

        g3_entry = 1'b1;
        step(1); g3_entry = 1'b0;
        check("R6 power-off clears boot pair", tx_wires0, 32'h0);
        step(3);
        check("R6 boot pair stays clear", tx_wires0, 32'h0);

        susp_warn_lvl = 1'b1; hw_reset_evt = 1'b1;
        step(1); hw_reset_evt = 1'b0;
        check("R7 no change yet", 32'(oob_ready), 32'h0);
        step(1);
        check("R7 oob_ready set", 32'(oob_ready), 32'h1);
        check("R7 boot not yet", tx_wires0, 32'h0);
        step(1);
        check("R7 boot check after hw reset", tx_wires0, 32'h0090_0000);
        check("R7 suspend not yet", tx_wires1, 32'h0);
        step(1);
        check("R7 suspend ack after hw reset", tx_wires1, 32'h0010_0000);
        susp_warn_lvl = 1'b0;
        step(1);

        plat_rst_lvl = 1'b1; plat_rst_evt = 1'b1;
        step(1); plat_rst_evt = 1'b0;
        check("R8 platform reset high", 32'(plat_state), 32'h3);
        check("R8 pulse on platform event", 32'(plat_chg), 32'h1);
        step(1);
        check("R8 pulse ends", 32'(plat_chg), 32'h0);
        check("R6 boot pair held", tx_wires0, 32'h0090_0000);
        step(5);
        finish_run();
    end
endmodule